// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer split across two clocks. The host reaches it through a plain register port on the bus clock, using a write strobe, a byte address, write data and combinational read data. The countdown, the early-warning event and the reset request are in a slow timebase domain, which in normal use is a 32.768 kHz clock. At that rate the time left in seconds is the counter value divided by 32768. Every configuration write is refused unless a 16-bit key has first been written to the lock register. Any other value written there locks the block again.

Software stages two 32-bit values, each as a high half and a low half. The first is the reset load, from which the counter starts. The second is the interrupt threshold, which raises the early interrupt when the counter reaches it. Writing the low half of the reset load commits both values. A toggle handshake carries the commit into the slow domain, and a busy flag stays high until the slow side acknowledges it. While counting is enabled the counter falls by one on each slow tick. On the step that lands on zero, and with reset enabled, it latches a reset event and pulses a reset request. The counter then stays at zero until the next commit. The slow domain sends a heartbeat toggle once per tick, and the bus side uses it to capture the counter and the raw event bits. This relies on the bus clock running at least four times faster than the slow clock.

Top module: `wdg_lockdog`

## Requirements
- R1: After reset the block is locked (register 0x20 reads 1). The control register, mask, staged loads, counter and status all read 0, and both `irq` and `rst_req` are low.
- R2: Writing 0xE551 in bits 15:0 of register 0x20 unlocks the block, after which 0x20 reads 0. Writing any other value locks it, after which 0x20 reads 1.
- R3: While the block is locked, writes to every register other than 0x20 are ignored. Their read-back values stay the same and no commit takes place.
- R4: The reset load is written at 0x04 (bits 31:16) and 0x00 (bits 15:0). The interrupt threshold is written at 0x30 (bits 31:16) and 0x2C (bits 15:0). Each register takes bits 15:0 of the write data and reads back the staged half in bits 15:0.
- R5: A write to 0x00 while unlocked and not busy commits both staged values and sets status bit 4 (busy). Busy clears once the counter has reloaded, within a few slow cycles. A write to 0x00 while busy updates the staged half but does not commit.
- R6: The counter reads back at 0x18 (bits 15:0) and 0x1C (bits 31:16). It decrements by one per slow tick while control bit 1 is set, and holds its value while that bit is clear.
- R7: Status bit 0 (raw interrupt) sets when a counting step lands on the interrupt threshold. The `irq` pin is the raw interrupt AND control bit 0 AND NOT mask bit 0 (register 0x14), and the mask has no effect on the raw bit.
- R8: When a counting step lands on zero with control bit 3 set, status bit 3 latches and `rst_req` is high for exactly one slow cycle. The counter then holds zero until the next commit. With bit 3 clear, no event occurs.
- R9: Writing 1 to bit 0 of register 0x0C clears the raw interrupt, and writing 1 to bit 3 clears the latched reset event.
- R10: Control bit 2 (mode) is stored and read back at 0x08 and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| slow_clk | input | 1 | Timebase clock for the counter |
| slow_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Early-warning interrupt, bus domain |
| rst_req | output | 1 | One-slow-cycle reset request |

## Verification
The assertions check the following on every cycle:
- the counter's one-step descent and its hold at zero;
- that a reset request lasts a single cycle and is always backed by the latched event;
- that a locked control write changes nothing;
- that a commit raises busy and the committed values stay frozen while busy is high.

Only the bench scenarios can show the end-to-end behaviour: the handshake latency as the busy flag falls, a second commit being refused mid-transfer, the interrupt appearing at the threshold and being masked and cleared, and the reset event firing once and staying cleared at zero.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_RLD_LO = 8'h00;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 8'h04;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CLR    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h14;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 8'h18;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] A_LOCK   = 8'h20;
  localparam logic [ADDR_W-1:0] A_ILD_LO = 8'h2C;
  localparam logic [ADDR_W-1:0] A_ILD_HI = 8'h30;

  localparam logic [15:0] UNLOCK_KEY = 16'hE551;

  localparam int CB_INT  = 0;
  localparam int CB_CNT  = 1;
  localparam int CB_MODE = 2;
  localparam int CB_RST  = 3;
  localparam int CTRL_W  = 4;

  localparam int SB_IRQ  = 0;
  localparam int SB_RST  = 3;
  localparam int SB_BUSY = 4;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [CNT_W-1:0]  rld_q,
  output logic [CNT_W-1:0]  ild_q,
  output logic              req_tgl,
  output logic              clr_irq_tgl,
  output logic              clr_rst_tgl,
  input  logic              ack_s,
  input  logic              hb_s,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              irq_raw_in,
  input  logic              rst_raw_in,
  output logic              irq
);
  localparam int HALF_W = CNT_W / 2;

  logic             locked;
  logic [CNT_W-1:0] rld_stage, ild_stage;
  logic             mask;
  logic             hb_prev;
  logic [CNT_W-1:0] cnt_cap;
  logic             irq_cap, rst_cap;
  logic             busy, wr_ok;

  assign busy  = req_tgl ^ ack_s;
  assign wr_ok = wr_en && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked      <= 1'b1;
      rld_stage   <= '0;
      ild_stage   <= '0;
      ctrl        <= '0;
      mask        <= 1'b0;
      rld_q       <= '0;
      ild_q       <= '0;
      req_tgl     <= 1'b0;
      clr_irq_tgl <= 1'b0;
      clr_rst_tgl <= 1'b0;
    end else begin
      if (wr_en && addr == A_LOCK)
        locked <= (wdata[15:0] != UNLOCK_KEY);
      if (wr_ok) begin
        case (addr)
          A_RLD_LO: begin
            rld_stage[HALF_W-1:0] <= wdata[HALF_W-1:0];
            if (!busy) begin
              rld_q   <= {rld_stage[CNT_W-1:HALF_W], wdata[HALF_W-1:0]};
              ild_q   <= ild_stage;
              req_tgl <= ~req_tgl;
            end
          end
          A_RLD_HI: rld_stage[CNT_W-1:HALF_W] <= wdata[HALF_W-1:0];
          A_ILD_LO: ild_stage[HALF_W-1:0]     <= wdata[HALF_W-1:0];
          A_ILD_HI: ild_stage[CNT_W-1:HALF_W] <= wdata[HALF_W-1:0];
          A_CTRL:   ctrl <= wdata[CTRL_W-1:0];
          A_MASK:   mask <= wdata[0];
          A_CLR: begin
            if (wdata[SB_IRQ]) clr_irq_tgl <= ~clr_irq_tgl;
            if (wdata[SB_RST]) clr_rst_tgl <= ~clr_rst_tgl;
          end
          default: ;
        endcase
      end
    end
  end

  // Capture of slow-domain state one heartbeat after it settles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_prev <= 1'b0;
      cnt_cap <= '0;
      irq_cap <= 1'b0;
      rst_cap <= 1'b0;
    end else if (hb_s != hb_prev) begin
      hb_prev <= hb_s;
      cnt_cap <= cnt_in;
      irq_cap <= irq_raw_in;
      rst_cap <= rst_raw_in;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RLD_LO: rdata[HALF_W-1:0] = rld_stage[HALF_W-1:0];
      A_RLD_HI: rdata[HALF_W-1:0] = rld_stage[CNT_W-1:HALF_W];
      A_ILD_LO: rdata[HALF_W-1:0] = ild_stage[HALF_W-1:0];
      A_ILD_HI: rdata[HALF_W-1:0] = ild_stage[CNT_W-1:HALF_W];
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl;
      A_MASK:   rdata[0]          = mask;
      A_CNT_LO: rdata[HALF_W-1:0] = cnt_cap[HALF_W-1:0];
      A_CNT_HI: rdata[HALF_W-1:0] = cnt_cap[CNT_W-1:HALF_W];
      A_LOCK:   rdata[0]          = locked;
      A_STAT: begin
        rdata[SB_IRQ]  = irq_cap;
        rdata[SB_RST]  = rst_cap;
        rdata[SB_BUSY] = busy;
      end
      default: ;
    endcase
  end

  assign irq = irq_cap && ctrl[CB_INT] && !mask;

  AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && addr == A_CTRL) |=> (ctrl == $past(ctrl))); // R3
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LOCK && wdata[15:0] == UNLOCK_KEY) |=> !locked); // R2
  AST_COMMIT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == A_RLD_LO && !busy) |=> busy); // R5
  AST_BUSY_FREEZES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rld_q) && $stable(ild_q))); // R5
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int CNT_W = 32
) (
  input  logic             slow_clk,
  input  logic             slow_rst_n,
  input  logic             cnt_en,
  input  logic             rst_en,
  input  logic             req_s,
  input  logic             clr_irq_s,
  input  logic             clr_rst_s,
  input  logic [CNT_W-1:0] rld,
  input  logic [CNT_W-1:0] ild,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_raw,
  output logic             rst_raw,
  output logic             rst_req,
  output logic             ack_tgl,
  output logic             hb_tgl
);
  logic [CNT_W-1:0] thr_q;
  logic             req_prev, ci_prev, cr_prev;
  logic             load_evt, ci_evt, cr_evt;
  logic [CNT_W-1:0] cnt_dec;

  assign load_evt = req_s ^ req_prev;
  assign ci_evt   = clr_irq_s ^ ci_prev;
  assign cr_evt   = clr_rst_s ^ cr_prev;
  assign cnt_dec  = cnt_q - CNT_W'(1);

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      cnt_q    <= '0;
      thr_q    <= '0;
      irq_raw  <= 1'b0;
      rst_raw  <= 1'b0;
      rst_req  <= 1'b0;
      ack_tgl  <= 1'b0;
      hb_tgl   <= 1'b0;
      req_prev <= 1'b0;
      ci_prev  <= 1'b0;
      cr_prev  <= 1'b0;
    end else begin
      req_prev <= req_s;
      ci_prev  <= clr_irq_s;
      cr_prev  <= clr_rst_s;
      hb_tgl   <= ~hb_tgl;
      rst_req  <= 1'b0;
      if (ci_evt) irq_raw <= 1'b0;
      if (cr_evt) rst_raw <= 1'b0;
      if (load_evt) begin
        cnt_q   <= rld;
        thr_q   <= ild;
        ack_tgl <= ~ack_tgl;
      end else if (cnt_en && cnt_q != '0) begin
        cnt_q <= cnt_dec;
        if (cnt_dec == thr_q) irq_raw <= 1'b1;
        if (cnt_dec == '0 && rst_en) begin
          rst_raw <= 1'b1;
          rst_req <= 1'b1;
        end
      end
    end
  end

  AST_STEP_DOWN: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (!load_evt && cnt_en && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)))); // R6
  AST_ZERO_HOLD: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    (!load_evt && cnt_q == '0) |=> (cnt_q == '0)); // R8
  AST_RST_REQ_SINGLE: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    rst_req |=> !rst_req); // R8
  AST_RST_REQ_LATCHED: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
    rst_req |-> rst_raw); // R8
endmodule

// File: rtl/wdg_lockdog.sv
module wdg_lockdog
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              slow_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int TO_SLOW_W = 5;
  localparam int TO_BUS_W  = 2;

  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  rld_q, ild_q, cnt_q;
  logic              req_tgl, clr_irq_tgl, clr_rst_tgl;
  logic              ack_tgl, hb_tgl, irq_raw, rst_raw;
  logic [TO_SLOW_W-1:0] to_slow, to_slow_s;
  logic [TO_BUS_W-1:0]  to_bus, to_bus_s;

  wdg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ctrl(ctrl), .rld_q(rld_q), .ild_q(ild_q),
    .req_tgl(req_tgl), .clr_irq_tgl(clr_irq_tgl), .clr_rst_tgl(clr_rst_tgl),
    .ack_s(to_bus_s[0]), .hb_s(to_bus_s[1]), .cnt_in(cnt_q),
    .irq_raw_in(irq_raw), .rst_raw_in(rst_raw), .irq(irq)
  );

  assign to_slow = {clr_rst_tgl, clr_irq_tgl, req_tgl, ctrl[CB_RST], ctrl[CB_CNT]};
  assign to_bus  = {hb_tgl, ack_tgl};

  wdg_sync #(.W(TO_SLOW_W), .STAGES(SYNC_DEPTH)) u_sync_slow (
    .clk(slow_clk), .rst_n(slow_rst_n), .d(to_slow), .q(to_slow_s)
  );
  wdg_sync #(.W(TO_BUS_W), .STAGES(SYNC_DEPTH)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d(to_bus), .q(to_bus_s)
  );

  wdg_core #(.CNT_W(CNT_W)) u_core (
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .cnt_en(to_slow_s[0]), .rst_en(to_slow_s[1]), .req_s(to_slow_s[2]),
    .clr_irq_s(to_slow_s[3]), .clr_rst_s(to_slow_s[4]),
    .rld(rld_q), .ild(ild_q), .cnt_q(cnt_q), .irq_raw(irq_raw),
    .rst_raw(rst_raw), .rst_req(rst_req), .ack_tgl(ack_tgl), .hb_tgl(hb_tgl)
  );
endmodule

// File: tb/wdg_lockdog_test.sv
module wdg_lockdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_HALF  = 40;
  localparam int NV = 18;

  logic clk = 1'b0, slow_clk = 1'b0;
  logic rst_n = 1'b0, slow_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, rst_req;

  int total = 0, bad = 0, pulses = 0;
  bit done = 0;

  wdg_lockdog uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #3;
    forever #(SLOW_HALF) slow_clk = ~slow_clk;
  end

  always @(negedge slow_clk) if (rst_req) pulses++;

  // {write, addr, data, expected read}
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h20, 32'h0,         32'h1},     // R1 locked
    {1'b0, 8'h08, 32'h0,         32'h0},     // R1 ctrl zero
    {1'b1, 8'h08, 32'hF,         32'h0},
    {1'b0, 8'h08, 32'h0,         32'h0},     // R3
    {1'b1, 8'h20, 32'hE551,      32'h0},
    {1'b0, 8'h20, 32'h0,         32'h0},     // R2 unlocked
    {1'b1, 8'h04, 32'h1234_ABCD, 32'h0},
    {1'b0, 8'h04, 32'h0,         32'hABCD},  // R4
    {1'b1, 8'h2C, 32'hFFFF_0042, 32'h0},
    {1'b0, 8'h2C, 32'h0,         32'h42},    // R4
    {1'b1, 8'h08, 32'h4,         32'h0},
    {1'b0, 8'h08, 32'h0,         32'h4},     // R10
    {1'b1, 8'h20, 32'h0,         32'h0},
    {1'b0, 8'h20, 32'h0,         32'h1},     // R2 relocked
    {1'b1, 8'h30, 32'h7,         32'h0},
    {1'b0, 8'h30, 32'h0,         32'h0},     // R3
    {1'b1, 8'h20, 32'hE552,      32'h0},
    {1'b0, 8'h20, 32'h0,         32'h1}      // R2 wrong key
  };
  localparam int VREQ [NV] = '{1,1,3,3,2,2,4,4,4,4,10,10,2,2,3,3,2,2};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input logic [31:0] act,
                         input logic [31:0] lo, input logic [31:0] hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  task automatic commit(input logic [31:0] rv, input logic [31:0] iv);
    wr(8'h04, rv >> 16);
    wr(8'h30, iv >> 16);
    wr(8'h2C, iv & 32'hFFFF);
    wr(8'h00, rv & 32'hFFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1; slow_rst_n = 1'b1;
    wait_slow(3);

    // R1 reset state at the pins and registers
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rd(8'h10, v); chk("R1 status", v, 32'h0);
    rd(8'h18, v); chk("R1 count", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], v);
        chk($sformatf("R%0d vector %0d", VREQ[i], i), v, VEC[i][31:0]);
      end
    end

    // R3: commit while locked does nothing
    wr(8'h00, 32'h55);
    rd(8'h00, v); chk("R3 locked stage", v, 32'h0);
    rd(8'h10, v); chk("R3 no busy", v, 32'h0);

    // R5: commit, busy, refused second commit
    wr(8'h20, 32'hE551);
    wr(8'h08, 32'h4);
    commit(32'h0001_0005, 32'h0);
    rd(8'h10, v); chk("R5 busy set", v & 32'h10, 32'h10);
    wr(8'h00, 32'h9);
    wait_slow(6);
    rd(8'h10, v); chk("R5 busy clear", v & 32'h10, 32'h0);
    rd(8'h18, v); chk("R5 count low", v, 32'h5);
    rd(8'h1C, v); chk("R6 count high", v, 32'h1);
    rd(8'h00, v); chk("R4 staged low kept", v, 32'h9);

    // R6: decrement and hold
    wr(8'h08, 32'h0);
    commit(32'd100, 32'd0);
    wait_slow(6);
    rd(8'h18, v); chk("R6 loaded", v, 32'd100);
    wr(8'h08, 32'h6);  // R10 mode bit set while counting
    wait_slow(10);
    wr(8'h08, 32'h0);
    wait_slow(5);
    rd(8'h18, c1); chk_rng("R6 R10 decrement", c1, 32'd87, 32'd93);
    wait_slow(5);
    rd(8'h18, v); chk("R6 hold", v, c1);

    // R7 / R9: interrupt at threshold, mask, clear
    commit(32'd40, 32'd30);
    wait_slow(6);
    wr(8'h08, 32'h3);
    chk("R7 irq low before", {31'b0, irq}, 32'h0);
    wait_slow(16);
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h1);
    chk("R7 masked", {31'b0, irq}, 32'h0);
    rd(8'h10, v); chk("R7 raw kept", v & 32'h1, 32'h1);
    wr(8'h14, 32'h0);
    wr(8'h0C, 32'h1);
    wait_slow(6);
    rd(8'h10, v); chk("R9 raw irq cleared", v & 32'h1, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);
    wait_slow(40);
    rd(8'h18, v); chk("R8 zero hold", v, 32'h0);
    rd(8'h10, v); chk("R8 no event when off", v & 32'h8, 32'h0);
    chk("R8 no pulse when off", pulses, 0);

    // R8 / R9: reset event
    wr(8'h08, 32'h0);
    commit(32'd12, 32'd50);
    wait_slow(6);
    wr(8'h08, 32'hA);
    wait_slow(25);
    rd(8'h10, v); chk("R8 event latched", v & 32'h8, 32'h8);
    chk("R8 one pulse", pulses, 1);
    rd(8'h18, v); chk("R8 count zero", v, 32'h0);
    wait_slow(10);
    chk("R8 still one pulse", pulses, 1);
    wr(8'h0C, 32'h8);
    wait_slow(6);
    rd(8'h10, v); chk("R9 event cleared", v & 32'h8, 32'h0);
    chk("R9 no new pulse", pulses, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule